// File: doc/BRIEF.md
# USB Transmit Pipe Buffer Controller

This block controls a single transmit packet buffer that two sides use in turn. While the CPU side owns the buffer, it writes bytes into it one at a time. It then issues a valid command through a 16-bit control register, and ownership passes to the serial-interface-engine (SIE) side. The SIE reads the packet out byte by byte, using the length reported by the block, and signals completion. Completion empties the buffer and gives it back to the CPU.

Two transfer modes are supported.

- **Non-continuous mode.** The block hands the buffer over by itself once a full maximum-size packet has been written.
- **Continuous mode.** Software collects several maximum-size packets and then hands them over in one step.

A clear command discards the bytes written so far. Issuing clear and valid together queues a zero-length packet. A data write and a control write may arrive in the same cycle. In that case the byte is stored first and the command then applies to the result.

Top module: `usb_tx_pipe_buf`

## Requirements
- R1: During reset the control register reads 0x0000 and the error flag is 0. On the first clock edge after reset is released, the ready bit (bit 13) becomes 1 and the register reads 0x2000.
- R2: A data write while ready stores the byte at the next free location and raises the length field (bits 11:0) by one at the next clock edge.
- R3: A control write with bit 15 set while ready gives the buffer to the SIE at the next edge. From then on, bit 15 reads 1, ready reads 0, the length is held, and the SIE reads the bytes in the order they were written.
- R4: A valid command with no bytes written hands over a packet of length 0.
- R5: In non-continuous mode (continuous input 0), the write that brings the length to MAXPKT (default 64) hands the buffer to the SIE at the same edge, with no command needed.
- R6: In continuous mode (continuous input 1), reaching MAXPKT or a multiple of it does not hand over the buffer. A later valid command sends all the bytes written.
- R7: A control write with bits 15 and 14 both set while ready discards the stored bytes and hands over a zero-length packet.
- R8: A control write with bit 14 alone while ready sets the length to 0 and keeps CPU ownership. The next bytes written start at the first location again.
- R9: Control writes made while ready is 0 are ignored: ownership, the length and the buffer data are unchanged.
- R10: An SIE completion pulse while the SIE owns the buffer returns it at the next edge. The register then reads 0x2000.
- R11: A data write made while the SIE owns the buffer is dropped, leaving the length and the buffer contents unchanged, and sets the sticky error flag. Only reset clears that flag.
- R12: A data write when the buffer already holds DEPTH bytes (default 256) is dropped and sets the error flag. The length never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cont_mode_i | input | 1 | 1 = continuous transfer mode, 0 = non-continuous |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 16 | Control write data (bit 15 valid, bit 14 clear) |
| ctl_rdata_o | output | 16 | Control register: {valid, 0, ready, 0, length[11:0]} |
| cpu_wr_i | input | 1 | CPU data byte write strobe |
| cpu_wdata_i | input | 8 | CPU data byte |
| err_o | output | 1 | Sticky dropped-write error flag |
| sie_own_o | output | 1 | SIE currently owns the buffer |
| sie_len_o | output | 12 | Packet length for the SIE to read |
| sie_rd_i | input | 1 | SIE read strobe; advances to the next byte |
| sie_rdata_o | output | 8 | Byte at the SIE read position |
| sie_done_i | input | 1 | SIE transmission complete pulse |

## Verification
Every register-visible result of a data write, command or completion pulse appears exactly one clock edge after the strobe. The bench therefore drives each strobe for one cycle and samples just after the following edge.

The SIE read byte is combinational from the read position. Each byte is compared before its read strobe, and the position advances at the edge that consumes it.

The automatic handoff is checked on the register value right after the write that reaches the maximum packet size. Ignored commands and dropped writes are checked on the unchanged length and on the bytes the SIE later reads out.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int unsigned LEN_W  = 12;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned REG_W  = 16;
    localparam int unsigned BIT_VAL = 15;
    localparam int unsigned BIT_CLR = 14;
    localparam int unsigned BIT_RDY = 13;

    typedef struct packed {
        logic             up;
        logic             sie_own;
        logic [LEN_W-1:0] cnt;
        logic [LEN_W-1:0] rptr;
        logic             err;
    } utx_state_t;
endpackage

// File: rtl/utx_buf_mem.sv
module utx_buf_mem #(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) store_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = store_q[raddr_i];
endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
    import utx_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned MAXPKT = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cont_mode_i,
    input  logic             cmd_val_i,
    input  logic             cmd_clr_i,
    input  logic             cpu_wr_i,
    input  logic             sie_rd_i,
    input  logic             sie_done_i,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_waddr_o,
    output logic [AW-1:0]    mem_raddr_o,
    output logic             ready_o,
    output logic             sie_own_o,
    output logic [LEN_W-1:0] len_o,
    output logic             err_o
);
    localparam logic [LEN_W-1:0] DEPTH_L  = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] MAXPKT_L = LEN_W'(MAXPKT);

    utx_state_t q, d;
    logic ready, we;

    always_comb begin
        d     = q;
        we    = 1'b0;
        d.up  = 1'b1;
        ready = q.up & ~q.sie_own;

        // data byte first, then any command in the same cycle
        if (cpu_wr_i) begin
            if (ready && (q.cnt < DEPTH_L)) begin
                we    = 1'b1;
                d.cnt = q.cnt + 1'b1;
            end else begin
                d.err = 1'b1;
            end
        end

        if (ready) begin
            if (cmd_clr_i) d.cnt = '0;
            if (cmd_val_i) begin
                d.sie_own = 1'b1;
            end else if (!cont_mode_i && !cmd_clr_i && we && (d.cnt == MAXPKT_L)) begin
                d.sie_own = 1'b1;
            end
        end

        if (q.sie_own) begin
            if (sie_rd_i && (q.rptr < q.cnt)) d.rptr = q.rptr + 1'b1;
            if (sie_done_i) begin
                d.sie_own = 1'b0;
                d.cnt     = '0;
                d.rptr    = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we_o    = we;
    assign mem_waddr_o = q.cnt[AW-1:0];
    assign mem_raddr_o = q.rptr[AW-1:0];
    assign ready_o     = ready;
    assign sie_own_o   = q.sie_own;
    assign len_o       = q.cnt;
    assign err_o       = q.err;
endmodule

// File: rtl/usb_tx_pipe_buf.sv
module usb_tx_pipe_buf
    import utx_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned MAXPKT = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cont_mode_i,
    input  logic              ctl_wr_i,
    input  logic [REG_W-1:0]  ctl_wdata_i,
    output logic [REG_W-1:0]  ctl_rdata_o,
    input  logic              cpu_wr_i,
    input  logic [DATA_W-1:0] cpu_wdata_i,
    output logic              err_o,
    output logic              sie_own_o,
    output logic [LEN_W-1:0]  sie_len_o,
    input  logic              sie_rd_i,
    output logic [DATA_W-1:0] sie_rdata_o,
    input  logic              sie_done_i
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic            mem_we, ready, own;
    logic [AW-1:0]   waddr, raddr;
    logic [LEN_W-1:0] len;
    logic [REG_W-3:0] unused_wbits;

    assign unused_wbits = ctl_wdata_i[REG_W-3:0];

    utx_ctrl #(.DEPTH(DEPTH), .MAXPKT(MAXPKT)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cont_mode_i(cont_mode_i),
        .cmd_val_i  (ctl_wr_i & ctl_wdata_i[BIT_VAL]),
        .cmd_clr_i  (ctl_wr_i & ctl_wdata_i[BIT_CLR]),
        .cpu_wr_i   (cpu_wr_i),
        .sie_rd_i   (sie_rd_i),
        .sie_done_i (sie_done_i),
        .mem_we_o   (mem_we),
        .mem_waddr_o(waddr),
        .mem_raddr_o(raddr),
        .ready_o    (ready),
        .sie_own_o  (own),
        .len_o      (len),
        .err_o      (err_o)
    );

    utx_buf_mem #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_mem (
        .clk    (clk),
        .we_i   (mem_we),
        .waddr_i(waddr),
        .wdata_i(cpu_wdata_i),
        .raddr_i(raddr),
        .rdata_o(sie_rdata_o)
    );

    always_comb begin
        ctl_rdata_o          = '0;
        ctl_rdata_o[BIT_VAL] = own;
        ctl_rdata_o[BIT_RDY] = ready;
        ctl_rdata_o[LEN_W-1:0] = len;
    end

    assign sie_own_o = own;
    assign sie_len_o = len;
endmodule

// File: rtl/utx_chk.sv
module utx_chk
    import utx_pkg::*;
#(
    parameter int unsigned DEPTH  = 256,
    parameter int unsigned MAXPKT = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cont_mode_i,
    input logic             ctl_wr_i,
    input logic [REG_W-1:0] ctl_wdata_i,
    input logic [REG_W-1:0] ctl_rdata_o,
    input logic             cpu_wr_i,
    input logic             sie_done_i,
    input logic             err_o
);
    logic             own, rdy;
    logic [LEN_W-1:0] len;
    assign own = ctl_rdata_o[BIT_VAL];
    assign rdy = ctl_rdata_o[BIT_RDY];
    assign len = ctl_rdata_o[LEN_W-1:0];

    // R9
    sie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own && !sie_done_i |=> own && !rdy && $stable(len));
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own && sie_done_i |=> !own && rdy && len == '0);
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R5
    auto_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cont_mode_i && rdy && cpu_wr_i && !ctl_wr_i && len == LEN_W'(MAXPKT - 1)
        |=> own && len == LEN_W'(MAXPKT));
    // R7
    zlp_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && ctl_wr_i && ctl_wdata_i[BIT_VAL] && ctl_wdata_i[BIT_CLR]
        |=> own && len == '0);
    // R8
    clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && ctl_wr_i && !ctl_wdata_i[BIT_VAL] && ctl_wdata_i[BIT_CLR]
        |=> !own && len == '0);
    // R12
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        len <= LEN_W'(DEPTH));
endmodule

bind usb_tx_pipe_buf utx_chk #(.DEPTH(DEPTH), .MAXPKT(MAXPKT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cont_mode_i(cont_mode_i),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_wdata_i(ctl_wdata_i),
    .ctl_rdata_o(ctl_rdata_o),
    .cpu_wr_i   (cpu_wr_i),
    .sie_done_i (sie_done_i),
    .err_o      (err_o)
);

// File: tb/tb_usb_tx_pipe_buf.sv
module tb_usb_tx_pipe_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cont_mode_i = 1'b0;
    logic        ctl_wr_i = 1'b0;
    logic [15:0] ctl_wdata_i = '0;
    logic [15:0] ctl_rdata_o;
    logic        cpu_wr_i = 1'b0;
    logic [7:0]  cpu_wdata_i = '0;
    logic        err_o, sie_own_o;
    logic [11:0] sie_len_o;
    logic        sie_rd_i = 1'b0;
    logic [7:0]  sie_rdata_o;
    logic        sie_done_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    usb_tx_pipe_buf dut (.*);

    always #4 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic tick;
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset;
        rst_n = 1'b0;
        tick; tick;
        check("R1 reg in reset", ctl_rdata_o, 16'h0000);
        check("R1 err in reset", err_o, 0);
        rst_n = 1'b1;
        tick;
        check("R1 ready after reset", ctl_rdata_o, 16'h2000);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        cpu_wr_i = 1'b1; cpu_wdata_i = b;
        tick;
        cpu_wr_i = 1'b0;
    endtask

    task automatic ctl(input logic v, input logic c);
        ctl_wr_i = 1'b1; ctl_wdata_i = {v, c, 14'h3FFF};
        tick;
        ctl_wr_i = 1'b0; ctl_wdata_i = '0;
    endtask

    task automatic sie_drain(input string req, input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            check(req, sie_rdata_o, 8'(base + i));
            sie_rd_i = 1'b1;
            tick;
            sie_rd_i = 1'b0;
        end
    endtask

    task automatic sie_finish;
        sie_done_i = 1'b1;
        tick;
        sie_done_i = 1'b0;
        check("R10 returned to cpu", ctl_rdata_o, 16'h2000);
    endtask

    task automatic t_short;
        cont_mode_i = 1'b0;
        for (int i = 0; i < 5; i++) wr_byte(8'h10 + 8'(i));
        check("R2 length counts writes", ctl_rdata_o, 16'h2005);
        ctl(1'b1, 1'b0);
        check("R3 handoff on valid", ctl_rdata_o, 16'h8005);
        check("R3 sie length", sie_len_o, 5);
        sie_drain("R3 byte order", 5, 8'h10);
        sie_finish;
    endtask

    task automatic t_zlp;
        ctl(1'b1, 1'b0);
        check("R4 zero length packet", ctl_rdata_o, 16'h8000);
        sie_finish;
    endtask

    task automatic t_noncont;
        cont_mode_i = 1'b0;
        for (int i = 0; i < 63; i++) wr_byte(8'h40 + 8'(i));
        check("R5 below max still cpu", ctl_rdata_o, 16'h203F);
        wr_byte(8'h40 + 8'd63);
        check("R5 auto handoff", ctl_rdata_o, 16'h8040);
        ctl(1'b1, 1'b0);
        check("R9 valid ignored", ctl_rdata_o, 16'h8040);
        ctl(1'b1, 1'b1);
        check("R9 valid+clear ignored", ctl_rdata_o, 16'h8040);
        check("R11 err before drop", err_o, 0);
        wr_byte(8'hEE);
        check("R11 dropped write length", ctl_rdata_o, 16'h8040);
        check("R11 err set", err_o, 1);
        sie_drain("R9 R11 data intact", 64, 8'h40);
        sie_finish;
        check("R11 err sticky", err_o, 1);
    endtask

    task automatic t_clear;
        for (int i = 0; i < 3; i++) wr_byte(8'h90);
        ctl(1'b0, 1'b1);
        check("R8 clear only", ctl_rdata_o, 16'h2000);
        wr_byte(8'hA0);
        wr_byte(8'hA1);
        ctl(1'b1, 1'b0);
        check("R8 restart length", ctl_rdata_o, 16'h8002);
        sie_drain("R8 pointer reset", 2, 8'hA0);
        sie_finish;
    endtask

    task automatic t_force_zlp;
        for (int i = 0; i < 4; i++) wr_byte(8'h55);
        ctl(1'b1, 1'b1);
        check("R7 forced zero length", ctl_rdata_o, 16'h8000);
        sie_finish;
    endtask

    task automatic t_cont;
        cont_mode_i = 1'b1;
        for (int i = 0; i < 64; i++) wr_byte(8'(i));
        check("R6 no auto handoff", ctl_rdata_o, 16'h2040);
        for (int i = 64; i < 128; i++) wr_byte(8'(i));
        check("R6 two packets held", ctl_rdata_o, 16'h2080);
        ctl(1'b1, 1'b0);
        check("R6 handoff multiple", ctl_rdata_o, 16'h8080);
        sie_drain("R6 data order", 128, 8'h00);
        sie_finish;
    endtask

    task automatic t_full;
        cont_mode_i = 1'b1;
        for (int i = 0; i < 256; i++) wr_byte(8'(i + 3));
        check("R12 full length", ctl_rdata_o, 16'h2100);
        check("R12 no err yet", err_o, 0);
        wr_byte(8'hCC);
        check("R12 overflow dropped", ctl_rdata_o, 16'h2100);
        check("R12 err set", err_o, 1);
        ctl(1'b1, 1'b0);
        sie_drain("R12 data intact", 256, 8'h03);
        sie_finish;
    endtask

    initial begin
        #1;
        do_reset;
        t_short;
        t_zlp;
        t_noncont;
        do_reset;
        t_clear;
        t_force_zlp;
        t_cont;
        do_reset;
        t_full;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule